// File: doc/BRIEF.md
# Pointer Address Unit

This block turns a 16-bit pointer, held as a pair of adjacent 8-bit registers, into the byte address used by a load or a store. It applies one of four addressing modes. It returns the effective address together with the updated pointer, and it raises a write-back strobe when the mode changes the pointer. Program-memory byte loads go through the same path. They always take their pointer from the last pair and accept only two of the modes.

The unit is purely combinational. The register file presents all pointer pairs on one flat bus. Decode supplies the request, the access type, the pair code, the mode and a 6-bit unsigned displacement. The address, the error flags and the write-back value are valid in the same cycle, so the register file captures the new pointer on the next clock edge. An address at or beyond the size of the target memory is reported as out of bounds, and the unit then blocks both the access and the write-back.

Top module: `ptr_agu`

## Requirements
- R1: Pair k is bits [16k+15:16k] of `ptr_file_i`, with the high register in the upper byte. In plain mode (`mode_i`=0) the address is the pair value and there is no write-back.
- R2: In pre-decrement mode (`mode_i`=1) the address is pointer-1, that same value is presented as the new pointer, and write-back is enabled.
- R3: In post-increment mode (`mode_i`=2) the address is the original pointer, the new pointer is pointer+1, and write-back is enabled.
- R4: In displacement mode (`mode_i`=3) the address is the pointer plus the zero-extended 6-bit `disp_i`, the new pointer equals the old one, and there is no write-back.
- R5: All pointer arithmetic wraps modulo 2^16 (0000-1 gives FFFF, FFFF+1 gives 0000, FFF0+63 gives 002F).
- R6: A program-memory load (`prog_i`=1) reads pair NUM_PAIRS-1 whatever `pair_sel_i` holds, and `wb_pair_o` reports that pair.
- R7: A program-memory load in pre-decrement or displacement mode raises `illegal_o`, with `go_o`, `wb_en_o` and `oob_o` low. The address and the new-pointer outputs are still computed.
- R8: An address at or above DMEM_BYTES (data) or PMEM_BYTES (program) raises `oob_o` and holds `go_o` and `wb_en_o` low. An address of size-1 is accepted.
- R9: A data access whose `pair_sel_i` is NUM_PAIRS or above raises `illegal_o` and uses pointer 0000.
- R10: With `req_i` low, `go_o`, `wb_en_o`, `illegal_o` and `oob_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_i | input | 1 | Access request strobe |
| prog_i | input | 1 | 1: program-memory byte load, 0: data load/store |
| pair_sel_i | input | 2 | Pointer pair code for data accesses |
| mode_i | input | 2 | 0 plain, 1 pre-decrement, 2 post-increment, 3 displacement |
| disp_i | input | 6 | Unsigned displacement |
| ptr_file_i | input | 48 | All pointer pairs, pair k at [16k+15:16k] |
| addr_o | output | 16 | Effective byte address |
| go_o | output | 1 | Access is legal and in range |
| wb_en_o | output | 1 | Write the new pointer back |
| wb_pair_o | output | 2 | Pair that receives the write-back |
| wb_lo_o | output | 8 | New pointer, low register |
| wb_hi_o | output | 8 | New pointer, high register |
| illegal_o | output | 1 | Unsupported mode or pair code |
| oob_o | output | 1 | Address outside the target memory |

## Verification
The bench puts distinct values in every pair, so a unit that read the wrong pair for a program load, or swapped the byte order, returns a visibly wrong address. It drives the wrap points 0000 pre-decrement, FFFF post-increment and FFF0 plus 63; a unit that truncated or sign-extended the displacement, or carried beyond 16 bits, would miss these. It probes both memory limits one below and exactly at the size, including a displacement that crosses the limit; an off-by-one compare accepts or rejects the wrong one. It also checks that a post-increment whose address is in range still writes back even when the new pointer lies outside, and that illegal or out-of-range accesses never strobe write-back.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;
  typedef enum logic [1:0] {
    AM_PLAIN   = 2'd0,
    AM_PREDEC  = 2'd1,
    AM_POSTINC = 2'd2,
    AM_DISP    = 2'd3
  } amode_e;
endpackage

// File: rtl/ptr_pair_mux.sv
module ptr_pair_mux #(
  parameter int unsigned NUM_PAIRS = 3,
  parameter int unsigned PTR_W     = 16,
  localparam int unsigned SEL_W    = $clog2(NUM_PAIRS)
) (
  input  logic [NUM_PAIRS*PTR_W-1:0] file_i,
  input  logic [SEL_W-1:0]           sel_i,
  output logic [PTR_W-1:0]           ptr_o,
  output logic                       hit_o
);
  logic [NUM_PAIRS-1:0] hit;

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_hit
    assign hit[k] = (sel_i == SEL_W'(k));
  end

  always_comb begin
    ptr_o = '0;
    for (int k = 0; k < NUM_PAIRS; k++) begin
      if (hit[k]) ptr_o = ptr_o | file_i[k*PTR_W +: PTR_W];
    end
  end

  assign hit_o = |hit;
endmodule

// File: rtl/ptr_ea_calc.sv
module ptr_ea_calc
  import ptr_agu_pkg::*;
#(
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned DISP_W = 6
) (
  input  logic [PTR_W-1:0]  ptr_i,
  input  amode_e            mode_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [PTR_W-1:0]  ea_o,
  output logic [PTR_W-1:0]  nxt_o,
  output logic              wb_o
);
  logic [PTR_W-1:0] dec, inc, off;

  assign dec = ptr_i - PTR_W'(1);
  assign inc = ptr_i + PTR_W'(1);
  assign off = ptr_i + PTR_W'(disp_i);

  always_comb begin
    ea_o  = ptr_i;
    nxt_o = ptr_i;
    wb_o  = 1'b0;
    unique case (mode_i)
      AM_PLAIN:   ;
      AM_PREDEC:  begin ea_o = dec; nxt_o = dec; wb_o = 1'b1; end
      AM_POSTINC: begin nxt_o = inc; wb_o = 1'b1; end
      AM_DISP:    ea_o = off;
      default:    ;
    endcase
  end
endmodule

// File: rtl/ptr_bound_chk.sv
module ptr_bound_chk #(
  parameter int unsigned PTR_W = 16,
  parameter int unsigned LIMIT = 4096
) (
  input  logic [PTR_W-1:0] addr_i,
  output logic             ok_o
);
  localparam bit FULL = (LIMIT >> PTR_W) != 0;

  if (FULL) begin : g_full
    logic unused;
    assign unused = ^addr_i;
    assign ok_o   = 1'b1;
  end else begin : g_cmp
    assign ok_o = 32'(addr_i) < LIMIT;
  end
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
  import ptr_agu_pkg::*;
#(
  parameter int unsigned NUM_PAIRS  = 3,
  parameter int unsigned REG_W      = 8,
  parameter int unsigned DISP_W     = 6,
  parameter int unsigned DMEM_BYTES = 4096,
  parameter int unsigned PMEM_BYTES = 8192,
  localparam int unsigned PTR_W     = 2 * REG_W,
  localparam int unsigned SEL_W     = $clog2(NUM_PAIRS)
) (
  input  logic                       req_i,
  input  logic                       prog_i,
  input  logic [SEL_W-1:0]           pair_sel_i,
  input  logic [1:0]                 mode_i,
  input  logic [DISP_W-1:0]          disp_i,
  input  logic [NUM_PAIRS*PTR_W-1:0] ptr_file_i,
  output logic [PTR_W-1:0]           addr_o,
  output logic                       go_o,
  output logic                       wb_en_o,
  output logic [SEL_W-1:0]           wb_pair_o,
  output logic [REG_W-1:0]           wb_lo_o,
  output logic [REG_W-1:0]           wb_hi_o,
  output logic                       illegal_o,
  output logic                       oob_o
);
  localparam logic [SEL_W-1:0] Z_SEL = SEL_W'(NUM_PAIRS - 1);

  amode_e           mode;
  logic [SEL_W-1:0] eff_sel;
  logic [PTR_W-1:0] ptr, ea, nxt;
  logic             pair_hit, wb_req, dm_ok, pm_ok;
  logic             mode_ok, legal, in_rng;

  assign mode    = amode_e'(mode_i);
  assign eff_sel = prog_i ? Z_SEL : pair_sel_i;

  ptr_pair_mux #(.NUM_PAIRS(NUM_PAIRS), .PTR_W(PTR_W)) u_mux (
    .file_i (ptr_file_i),
    .sel_i  (eff_sel),
    .ptr_o  (ptr),
    .hit_o  (pair_hit)
  );

  ptr_ea_calc #(.PTR_W(PTR_W), .DISP_W(DISP_W)) u_ea (
    .ptr_i  (ptr),
    .mode_i (mode),
    .disp_i (disp_i),
    .ea_o   (ea),
    .nxt_o  (nxt),
    .wb_o   (wb_req)
  );

  ptr_bound_chk #(.PTR_W(PTR_W), .LIMIT(DMEM_BYTES)) u_dm_bnd (
    .addr_i (ea),
    .ok_o   (dm_ok)
  );

  ptr_bound_chk #(.PTR_W(PTR_W), .LIMIT(PMEM_BYTES)) u_pm_bnd (
    .addr_i (ea),
    .ok_o   (pm_ok)
  );

  // program loads only know plain and post-increment
  assign mode_ok = !prog_i || (mode == AM_PLAIN) || (mode == AM_POSTINC);
  assign legal   = mode_ok && pair_hit;
  assign in_rng  = prog_i ? pm_ok : dm_ok;

  assign illegal_o = req_i && !legal;
  assign oob_o     = req_i && legal && !in_rng;
  assign go_o      = req_i && legal && in_rng;
  assign wb_en_o   = go_o && wb_req;
  assign wb_pair_o = eff_sel;
  assign addr_o    = ea;
  assign wb_lo_o   = nxt[REG_W-1:0];
  assign wb_hi_o   = nxt[PTR_W-1:REG_W];
endmodule

// File: rtl/ptr_agu_chk.sv
module ptr_agu_chk #(
  parameter int unsigned NUM_PAIRS = 3,
  parameter int unsigned REG_W     = 8,
  parameter int unsigned DISP_W    = 6,
  localparam int unsigned PTR_W    = 2 * REG_W,
  localparam int unsigned SEL_W    = $clog2(NUM_PAIRS)
) (
  input logic              req_i,
  input logic              prog_i,
  input logic [1:0]        mode_i,
  input logic [PTR_W-1:0]  addr_o,
  input logic              go_o,
  input logic              wb_en_o,
  input logic [SEL_W-1:0]  wb_pair_o,
  input logic [REG_W-1:0]  wb_lo_o,
  input logic [REG_W-1:0]  wb_hi_o,
  input logic              illegal_o,
  input logic              oob_o
);
  logic [PTR_W-1:0] nxt;
  assign nxt = {wb_hi_o, wb_lo_o};

  always_comb begin
    assert_idle_quiet_R10: assert (req_i || !(go_o || wb_en_o || illegal_o || oob_o));
    assert_go_clean_R8: assert (!go_o || (!illegal_o && !oob_o));
    assert_wb_needs_go_R7: assert (!wb_en_o || go_o);
    assert_err_exclusive_R7: assert (!(illegal_o && oob_o));
    assert_plain_no_wb_R1: assert (!(mode_i == 2'd0) || !wb_en_o);
    assert_disp_no_wb_R4: assert (!(mode_i == 2'd3) || !wb_en_o);
    assert_predec_same_R2: assert (!(req_i && mode_i == 2'd1) || nxt == addr_o);
    assert_postinc_step_R3: assert (!(req_i && mode_i == 2'd2) || nxt == addr_o + PTR_W'(1));
    assert_prog_pair_R6: assert (!(req_i && prog_i) || wb_pair_o == SEL_W'(NUM_PAIRS - 1));
  end
endmodule

bind ptr_agu ptr_agu_chk #(
  .NUM_PAIRS (NUM_PAIRS),
  .REG_W     (REG_W),
  .DISP_W    (DISP_W)
) i_ptr_agu_chk (
  .req_i     (req_i),
  .prog_i    (prog_i),
  .mode_i    (mode_i),
  .addr_o    (addr_o),
  .go_o      (go_o),
  .wb_en_o   (wb_en_o),
  .wb_pair_o (wb_pair_o),
  .wb_lo_o   (wb_lo_o),
  .wb_hi_o   (wb_hi_o),
  .illegal_o (illegal_o),
  .oob_o     (oob_o)
);

// File: tb/test_ptr_agu.sv
module test_ptr_agu;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;

  typedef struct packed {
    logic        prog;
    logic [1:0]  sel;
    logic [1:0]  mode;
    logic [5:0]  disp;
    logic [15:0] ptr;
    logic [15:0] addr;
    logic        go;
    logic        wb;
    logic [15:0] wbv;
    logic        ill;
    logic        oob;
  } vec_t;

  // prog, sel, mode, disp, ptr | addr, go, wb, new ptr, illegal, oob
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 2'd0, 6'd0,  16'h0123, 16'h0123, 1'b1, 1'b0, 16'h0123, 1'b0, 1'b0}, // R1
    '{1'b0, 2'd1, 2'd0, 6'd0,  16'h0FFF, 16'h0FFF, 1'b1, 1'b0, 16'h0FFF, 1'b0, 1'b0}, // R1
    '{1'b0, 2'd2, 2'd1, 6'd0,  16'h0200, 16'h01FF, 1'b1, 1'b1, 16'h01FF, 1'b0, 1'b0}, // R2
    '{1'b0, 2'd0, 2'd2, 6'd0,  16'h0340, 16'h0340, 1'b1, 1'b1, 16'h0341, 1'b0, 1'b0}, // R3
    '{1'b0, 2'd1, 2'd3, 6'd63, 16'h0100, 16'h013F, 1'b1, 1'b0, 16'h0100, 1'b0, 1'b0}, // R4
    '{1'b0, 2'd2, 2'd3, 6'd0,  16'h0100, 16'h0100, 1'b1, 1'b0, 16'h0100, 1'b0, 1'b0}, // R4
    '{1'b0, 2'd0, 2'd1, 6'd0,  16'h0000, 16'hFFFF, 1'b0, 1'b0, 16'hFFFF, 1'b0, 1'b1}, // R5
    '{1'b0, 2'd1, 2'd2, 6'd0,  16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1}, // R5
    '{1'b0, 2'd2, 2'd3, 6'd63, 16'hFFF0, 16'h002F, 1'b1, 1'b0, 16'hFFF0, 1'b0, 1'b0}, // R5
    '{1'b1, 2'd0, 2'd0, 6'd0,  16'h1234, 16'h1234, 1'b1, 1'b0, 16'h1234, 1'b0, 1'b0}, // R6
    '{1'b1, 2'd1, 2'd2, 6'd0,  16'h00FF, 16'h00FF, 1'b1, 1'b1, 16'h0100, 1'b0, 1'b0}, // R6
    '{1'b1, 2'd0, 2'd1, 6'd0,  16'h0010, 16'h000F, 1'b0, 1'b0, 16'h000F, 1'b1, 1'b0}, // R7
    '{1'b1, 2'd1, 2'd3, 6'd5,  16'h0010, 16'h0015, 1'b0, 1'b0, 16'h0010, 1'b1, 1'b0}, // R7
    '{1'b0, 2'd0, 2'd0, 6'd0,  16'h1000, 16'h1000, 1'b0, 1'b0, 16'h1000, 1'b0, 1'b1}, // R8
    '{1'b0, 2'd0, 2'd2, 6'd0,  16'h0FFF, 16'h0FFF, 1'b1, 1'b1, 16'h1000, 1'b0, 1'b0}, // R8
    '{1'b1, 2'd2, 2'd0, 6'd0,  16'h1FFF, 16'h1FFF, 1'b1, 1'b0, 16'h1FFF, 1'b0, 1'b0}, // R8
    '{1'b1, 2'd0, 2'd2, 6'd0,  16'h2000, 16'h2000, 1'b0, 1'b0, 16'h2001, 1'b0, 1'b1}, // R8
    '{1'b0, 2'd3, 2'd3, 6'd4,  16'h0000, 16'h0004, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0}, // R9
    '{1'b0, 2'd1, 2'd3, 6'd1,  16'h0FFF, 16'h1000, 1'b0, 1'b0, 16'h0FFF, 1'b0, 1'b1}  // R8
  };
  localparam logic [47:0] BASE = {16'h0CCC, 16'h0BBB, 16'h0AAA};

  logic        clk = 1'b0;
  logic        req_i, prog_i;
  logic [1:0]  pair_sel_i, mode_i, wb_pair_o;
  logic [5:0]  disp_i;
  logic [47:0] ptr_file_i;
  logic [15:0] addr_o;
  logic [7:0]  wb_lo_o, wb_hi_o;
  logic        go_o, wb_en_o, illegal_o, oob_o;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_agu i_ptr_agu (
    .req_i      (req_i),
    .prog_i     (prog_i),
    .pair_sel_i (pair_sel_i),
    .mode_i     (mode_i),
    .disp_i     (disp_i),
    .ptr_file_i (ptr_file_i),
    .addr_o     (addr_o),
    .go_o       (go_o),
    .wb_en_o    (wb_en_o),
    .wb_pair_o  (wb_pair_o),
    .wb_lo_o    (wb_lo_o),
    .wb_hi_o    (wb_hi_o),
    .illegal_o  (illegal_o),
    .oob_o      (oob_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic req, input logic prog, input logic [1:0] sel,
                       input logic [1:0] mode, input logic [5:0] disp, input logic [15:0] ptr);
    int tgt;
    @(negedge clk);
    tgt        = prog ? 2 : int'(sel);
    ptr_file_i = BASE;
    if (tgt < 3) ptr_file_i[tgt*16 +: 16] = ptr;
    req_i      = req;
    prog_i     = prog;
    pair_sel_i = sel;
    mode_i     = mode;
    disp_i     = disp;
    #(CLK_PERIOD/4);
  endtask

  initial begin
    req_i = 1'b0; prog_i = 1'b0; pair_sel_i = '0; mode_i = '0; disp_i = '0; ptr_file_i = BASE;
    #(CLK_PERIOD/4);
    // idle state: R10
    chk("R10 idle flags", {28'd0, go_o, wb_en_o, illegal_o, oob_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      apply(1'b1, VEC[i].prog, VEC[i].sel, VEC[i].mode, VEC[i].disp, VEC[i].ptr);
      chk($sformatf("vec%0d addr", i), {16'd0, addr_o}, {16'd0, VEC[i].addr});
      chk($sformatf("vec%0d newptr", i), {16'd0, wb_hi_o, wb_lo_o}, {16'd0, VEC[i].wbv});
      chk($sformatf("vec%0d flags", i), {28'd0, go_o, wb_en_o, illegal_o, oob_o},
          {28'd0, VEC[i].go, VEC[i].wb, VEC[i].ill, VEC[i].oob});
      if (VEC[i].prog) chk($sformatf("R6 vec%0d wb pair", i), {30'd0, wb_pair_o}, 32'd2);
      else if (VEC[i].sel != 2'd3) chk($sformatf("R1 vec%0d wb pair", i), {30'd0, wb_pair_o}, {30'd0, VEC[i].sel});
    end

    // R10: request low with a write-back mode and an out-of-range pointer
    apply(1'b0, 1'b0, 2'd1, 2'd1, 6'd0, 16'h0200);
    chk("R10 no req predec", {28'd0, go_o, wb_en_o, illegal_o, oob_o}, 32'd0);
    apply(1'b0, 1'b1, 2'd0, 2'd3, 6'd0, 16'h8000);
    chk("R10 no req illegal", {28'd0, go_o, wb_en_o, illegal_o, oob_o}, 32'd0);
    // R1: byte order, high register in the upper byte
    apply(1'b1, 1'b0, 2'd2, 2'd0, 6'd0, 16'h0A5C);
    chk("R1 byte order", {16'd0, addr_o}, 32'h0A5C);
    // R6: program load ignores pair code 3
    apply(1'b1, 1'b1, 2'd3, 2'd0, 6'd0, 16'h0042);
    chk("R6 sel ignored", {16'd0, addr_o}, 32'h0042);
    chk("R6 sel ignored flags", {28'd0, go_o, wb_en_o, illegal_o, oob_o}, 32'b1000);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule